// File: doc/BRIEF.md
# Buck PWM Phase Sequencer with Blanked Overcurrent Sampling

This block produces the two gate commands of one synchronous buck stage from a free-running tick counter. Each switching cycle starts with the high-side enable and hands over to the low-side enable for the rest of the cycle. The period and the requested high-side on-time are given in clock ticks. Both are captured once per cycle, at the cycle boundary.

The block reserves a minimum low-side interval in every cycle by cutting back the requested high-side time when needed. Inside that interval it opens a sense window once a fixed blanking time has passed after the low-side turn-on. Switching noise therefore never reaches the overcurrent decision. A raw comparator bit is qualified by this window, and the first qualified high sample in a cycle produces a one-tick detection pulse. A force-off input removes both gate commands at once and keeps the window shut for the rest of the cycle.

Top module: `ocp_window_gen`

## Requirements
- R1: While `rst_n` is low, and in the first tick after it rises, all four outputs are low. The first cycle begins on the first clock edge after release.
- R2: A cycle lasts P = max(`period_i`, MIN_LS_TICKS) ticks. `hs_en_o` is high for the first D ticks of the cycle and `ls_en_o` is high for the remaining P−D ticks, unless force-off is active.
- R3: `hs_en_o` and `ls_en_o` are never high in the same tick.
- R4: D = min(`duty_i`, P − MIN_LS_TICKS), so the low-side interval of an unforced cycle is never shorter than MIN_LS_TICKS ticks.
- R5: `win_o` is high exactly in the low-side ticks whose index counted from the low-side turn-on is at least BLANK_TICKS. It closes when `ls_en_o` falls.
- R6: `oc_det_o` is high for one tick, in the same tick as the first sample in a cycle where `win_o` and `oc_raw_i` are both high. It fires at most once per cycle.
- R7: `oc_raw_i` has no effect while the window is closed: during the high-side interval and during the blanking ticks.
- R8: While `force_off_i` is high, both enables and the window are low in that same tick. After force-off, the window stays closed until the next cycle starts, and the tick count of the cycle continues unchanged.
- R9: A change of `period_i` or `duty_i` during a cycle has no effect until the next cycle boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | CNT_W | Requested cycle length in ticks |
| duty_i | input | CNT_W | Requested high-side on-time in ticks |
| oc_raw_i | input | 1 | Raw overcurrent comparator bit |
| force_off_i | input | 1 | Immediate shutdown of both gate commands |
| hs_en_o | output | 1 | High-side gate command |
| ls_en_o | output | 1 | Low-side gate command |
| win_o | output | 1 | Overcurrent sense window open |
| oc_det_o | output | 1 | One-tick overcurrent detection pulse |

## Verification
The tick counter and the captured duty are state that the ports do not show. If either is wrong, the hand-over tick of the enables moves, and a per-tick comparison catches that inside the same cycle. Faults in the blanking or abort state show up as a window that opens one tick early or late, or as a window that reopens after a force-off. A detection latch that fails to clear or to set shows up as a missing pulse or a repeated pulse within one cycle. Cycle-level tick totals also confirm the clamp, and confirm that a captured setting is applied one boundary late.

// File: rtl/ocpw_pkg.sv
package ocpw_pkg;

  // Per-tick switching phase of the power stage
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } phase_e;

endpackage

// File: rtl/ocpw_cycle_timer.sv
module ocpw_cycle_timer #(
  parameter int CNT_W        = 12,
  parameter int MIN_LS_TICKS = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] duty_o,
  output logic             run_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] MIN_LS_W = CNT_W'(MIN_LS_TICKS);
  localparam logic [CNT_W-1:0] ONE_W    = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic [CNT_W-1:0] duty_q, duty_d;
  logic             run_q;
  logic [CNT_W-1:0] per_eff, duty_cap, duty_eff;
  logic             wrap;

  // Settings are qualified here and captured only on a cycle boundary
  always_comb begin
    per_eff  = (period_i < MIN_LS_W) ? MIN_LS_W : period_i;
    duty_cap = per_eff - MIN_LS_W;
    duty_eff = (duty_i > duty_cap) ? duty_cap : duty_i;
    wrap     = !run_q || (cnt_q >= per_q - ONE_W);
    if (wrap) begin
      cnt_d  = '0;
      per_d  = per_eff;
      duty_d = duty_eff;
    end else begin
      cnt_d  = cnt_q + ONE_W;
      per_d  = per_q;
      duty_d = duty_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      per_q  <= MIN_LS_W;
      duty_q <= '0;
      run_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      per_q  <= per_d;
      duty_q <= duty_d;
      run_q  <= 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign duty_o = duty_q;
  assign run_o  = run_q;
  assign wrap_o = wrap;

endmodule

// File: rtl/ocpw_gate_phase.sv
module ocpw_gate_phase #(
  parameter int CNT_W = 12
) (
  input  logic              run_i,
  input  logic              force_off_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]  duty_i,
  output ocpw_pkg::phase_e  phase_o,
  output logic [CNT_W-1:0]  ls_age_o,
  output logic              hs_en_o,
  output logic              ls_en_o
);

  import ocpw_pkg::*;

  phase_e phase;

  // Force-off acts combinationally so the stage drops in the same tick
  always_comb begin
    if (!run_i || force_off_i) begin
      phase = PH_IDLE;
    end else if (cnt_i < duty_i) begin
      phase = PH_HIGH;
    end else begin
      phase = PH_LOW;
    end
  end

  assign phase_o  = phase;
  assign ls_age_o = cnt_i - duty_i;
  assign hs_en_o  = (phase == PH_HIGH);
  assign ls_en_o  = (phase == PH_LOW);

endmodule

// File: rtl/ocpw_sense_window.sv
module ocpw_sense_window #(
  parameter int CNT_W       = 12,
  parameter int BLANK_TICKS = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ocpw_pkg::phase_e  phase_i,
  input  logic [CNT_W-1:0]  ls_age_i,
  input  logic              wrap_i,
  input  logic              force_off_i,
  input  logic              oc_raw_i,
  output logic              win_o,
  output logic              oc_det_o
);

  import ocpw_pkg::*;

  localparam logic [CNT_W-1:0] BLANK_W = CNT_W'(BLANK_TICKS);

  logic abort_q, abort_d;
  logic seen_q, seen_d;
  logic blank_done;
  logic win, det;

  always_comb begin
    blank_done = (ls_age_i >= BLANK_W);
    win        = (phase_i == PH_LOW) && !abort_q && blank_done;
    det        = win && oc_raw_i && !seen_q;
    // Abort holds for the rest of the cycle; a force at the boundary carries over
    if (force_off_i) begin
      abort_d = 1'b1;
    end else if (wrap_i) begin
      abort_d = 1'b0;
    end else begin
      abort_d = abort_q;
    end
    seen_d = wrap_i ? 1'b0 : (seen_q || det);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_q <= 1'b0;
      seen_q  <= 1'b0;
    end else begin
      abort_q <= abort_d;
      seen_q  <= seen_d;
    end
  end

  assign win_o    = win;
  assign oc_det_o = det;

endmodule

// File: rtl/ocp_window_gen.sv
module ocp_window_gen #(
  parameter int CNT_W        = 12,
  parameter int BLANK_TICKS  = 20,
  parameter int MIN_LS_TICKS = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic             oc_raw_i,
  input  logic             force_off_i,
  output logic             hs_en_o,
  output logic             ls_en_o,
  output logic             win_o,
  output logic             oc_det_o
);

  import ocpw_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] duty_cur;
  logic [CNT_W-1:0] ls_age;
  logic             run;
  logic             wrap;
  phase_e           phase;

  ocpw_cycle_timer #(
    .CNT_W        (CNT_W),
    .MIN_LS_TICKS (MIN_LS_TICKS)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .period_i (period_i),
    .duty_i   (duty_i),
    .cnt_o    (cnt),
    .duty_o   (duty_cur),
    .run_o    (run),
    .wrap_o   (wrap)
  );

  ocpw_gate_phase #(
    .CNT_W (CNT_W)
  ) u_phase (
    .run_i       (run),
    .force_off_i (force_off_i),
    .cnt_i       (cnt),
    .duty_i      (duty_cur),
    .phase_o     (phase),
    .ls_age_o    (ls_age),
    .hs_en_o     (hs_en_o),
    .ls_en_o     (ls_en_o)
  );

  ocpw_sense_window #(
    .CNT_W       (CNT_W),
    .BLANK_TICKS (BLANK_TICKS)
  ) u_window (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_i     (phase),
    .ls_age_i    (ls_age),
    .wrap_i      (wrap),
    .force_off_i (force_off_i),
    .oc_raw_i    (oc_raw_i),
    .win_o       (win_o),
    .oc_det_o    (oc_det_o)
  );

endmodule

// File: rtl/ocpw_checker.sv
module ocpw_checker (
  input logic clk,
  input logic rst_n,
  input logic oc_raw_i,
  input logic force_off_i,
  input logic hs_en_o,
  input logic ls_en_o,
  input logic win_o,
  input logic oc_det_o
);

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!hs_en_o && !ls_en_o && !win_o && !oc_det_o);
    end
  end

  // R3
  gates_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_en_o && ls_en_o));

  // R8
  force_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_off_i |-> (!hs_en_o && !ls_en_o && !win_o));

  // R5
  window_inside_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_o |-> ls_en_o);

  // R5
  blank_at_turn_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_en_o) |-> !win_o);

  // R6
  det_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_det_o |-> (win_o && oc_raw_i));

  // R6
  det_single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_det_o |=> !oc_det_o);

endmodule

bind ocp_window_gen ocpw_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .oc_raw_i    (oc_raw_i),
  .force_off_i (force_off_i),
  .hs_en_o     (hs_en_o),
  .ls_en_o     (ls_en_o),
  .win_o       (win_o),
  .oc_det_o    (oc_det_o)
);

// File: tb/ocp_window_gen_tb.sv
module ocp_window_gen_tb;

  localparam int CW = 12;
  localparam int BL = 20;
  localparam int ML = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] period_i = '0;
  logic [CW-1:0] duty_i = '0;
  logic          oc_raw_i = 1'b0;
  logic          force_off_i = 1'b0;
  logic          hs_en_o, ls_en_o, win_o, oc_det_o;

  always #4 clk = ~clk;

  ocp_window_gen #(.CNT_W(CW), .BLANK_TICKS(BL), .MIN_LS_TICKS(ML)) u_dut (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .duty_i(duty_i),
    .oc_raw_i(oc_raw_i), .force_off_i(force_off_i),
    .hs_en_o(hs_en_o), .ls_en_o(ls_en_o), .win_o(win_o), .oc_det_o(oc_det_o)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;

  // behavioural reference state
  int m_run = 0, m_cnt = 0, m_per = ML, m_duty = 0, m_abort = 0, m_seen = 0;
  int c_hs, c_ls, c_win, c_det;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Called at a falling edge with inputs already applied
  task automatic step();
    int e_hs, e_ls, e_win, e_det, f, wrap, p;
    #1;
    f = int'(force_off_i);
    if (!rst_n || !m_run) begin
      e_hs = 0; e_ls = 0; e_win = 0; e_det = 0;
    end else begin
      e_hs  = (m_cnt < m_duty && f == 0) ? 1 : 0;
      e_ls  = (m_cnt >= m_duty && f == 0) ? 1 : 0;
      e_win = (e_ls == 1 && m_abort == 0 && (m_cnt - m_duty) >= BL) ? 1 : 0;
      e_det = (e_win == 1 && oc_raw_i && m_seen == 0) ? 1 : 0;
    end
    check("R2", "hs_en", int'(hs_en_o), e_hs);
    check("R2", "ls_en", int'(ls_en_o), e_ls);
    check("R5", "win", int'(win_o), e_win);
    check("R6", "oc_det", int'(oc_det_o), e_det);
    c_hs += int'(hs_en_o); c_ls += int'(ls_en_o);
    c_win += int'(win_o); c_det += int'(oc_det_o);
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_per = ML; m_duty = 0; m_abort = 0; m_seen = 0;
    end else begin
      wrap = (m_run == 0 || m_cnt >= m_per - 1) ? 1 : 0;
      m_seen = (wrap == 1) ? 0 : ((m_seen == 1 || e_det == 1) ? 1 : 0);
      m_abort = (f == 1) ? 1 : ((wrap == 1) ? 0 : m_abort);
      if (wrap == 1) begin
        p = (int'(period_i) < ML) ? ML : int'(period_i);
        m_per = p;
        m_duty = (int'(duty_i) > p - ML) ? p - ML : int'(duty_i);
        m_cnt = 0;
      end else begin
        m_cnt = m_cnt + 1;
      end
      m_run = 1;
    end
    @(negedge clk);
  endtask

  // Run until the next presented tick is the first of a cycle
  task automatic align();
    do step(); while (!(m_run == 1 && m_cnt == 0));
  endtask

  // mode: 0 quiet, 1 oc always, 2 oc only in high side and blanking,
  // 3 oc burst late in window, 4 force mid window, 5 duty change mid cycle
  task automatic run_pat(int cycles, int per, int mode);
    c_hs = 0; c_ls = 0; c_win = 0; c_det = 0;
    for (int i = 0; i < cycles * per; i++) begin
      int t;
      t = i % per;
      case (mode)
        1: oc_raw_i = 1'b1;
        2: oc_raw_i = (t < 60);
        3: oc_raw_i = (t >= 70 && t < 76);
        4: begin
          force_off_i = (t >= 65 && t <= 67);
          oc_raw_i = (t >= 70);
        end
        5: if (i == 20) duty_i = CW'(10);
        default: oc_raw_i = 1'b0;
      endcase
      step();
    end
    oc_raw_i = 1'b0;
    force_off_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset holds everything low
    for (int k = 0; k < 4; k++) begin
      #1;
      check("R1", "outputs in reset", int'({hs_en_o, ls_en_o, win_o, oc_det_o}), 0);
      @(negedge clk);
    end
    period_i = CW'(100);
    duty_i = CW'(40);
    step();
    rst_n = 1'b1;
    #1;
    check("R1", "outputs first tick after release", int'({hs_en_o, ls_en_o, win_o, oc_det_o}), 0);
    step();

    // R2 R5: nominal cycle totals
    align();
    run_pat(2, 100, 0);
    check("R2", "hs ticks in 2 cycles", c_hs, 80);
    check("R2", "ls ticks in 2 cycles", c_ls, 120);
    check("R5", "window ticks in 2 cycles", c_win, 80);
    check("R3", "hs plus ls ticks", c_hs + c_ls, 200);

    // R4: clamp of an oversized request
    duty_i = CW'(90);
    align();
    run_pat(2, 100, 0);
    check("R4", "clamped hs ticks", c_hs, 140);
    check("R4", "minimum ls ticks", c_ls, 60);

    // R4: full-duty request at a long period
    period_i = CW'(333);
    duty_i = CW'(333);
    align();
    run_pat(1, 333, 0);
    check("R4", "hs ticks at full request", c_hs, 303);
    check("R4", "ls ticks at full request", c_ls, 30);

    // R2: period below the floor stretches to the minimum low-side time
    period_i = CW'(10);
    duty_i = CW'(5);
    align();
    run_pat(2, 30, 0);
    check("R2", "hs ticks at floor period", c_hs, 0);
    check("R2", "ls ticks at floor period", c_ls, 60);

    period_i = CW'(100);
    duty_i = CW'(40);
    align();
    // R6: steady overcurrent gives one pulse per cycle
    run_pat(3, 100, 1);
    check("R6", "pulses with oc held high", c_det, 3);
    // R7: oc outside the window is ignored
    run_pat(2, 100, 2);
    check("R7", "pulses with oc in high side and blanking", c_det, 0);
    // R6: short late burst detected once
    run_pat(2, 100, 3);
    check("R6", "pulses with late burst", c_det, 2);
    // R8: force-off aborts the window for the rest of the cycle
    run_pat(1, 100, 4);
    check("R8", "window ticks with force", c_win, 5);
    check("R8", "pulses after force", c_det, 0);
    check("R8", "ls ticks with force", c_ls, 57);
    check("R8", "hs ticks with force", c_hs, 40);
    // R8: the next cycle is back to normal
    run_pat(1, 100, 1);
    check("R8", "pulse in cycle after force", c_det, 1);
    // R9: mid-cycle duty change applies one boundary later
    run_pat(2, 100, 5);
    check("R9", "hs ticks across duty change", c_hs, 50);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule